// File: doc/BRIEF.md
# Host Shared-Window Map Manager

This block sits on the host processor's bus and controls where each of four guest processors sees its small shared dual-port RAM window. It decodes each host address in two stages. A coarse stage compares the upper address bits and picks out one guest's 2 KB data window or the shared control block. A fine stage looks at the low byte bits inside the control block and finds individual control bytes.

Each guest has one placement bit. When the bit is 1, the guest's local decoder puts the shared window at address 0. When the bit is 0, the window moves to the 512 KB boundary. Only the host can change these bits, by writing to per-guest set and clear bytes. A guest that has hung can therefore be moved without a reset. The bits drive the guest-side decoders directly. Reading any byte of the control block returns all four bits.

Top module: `hsw_map_mgr`

## Requirements
- R1: While reset is low, and after it is released, every placement bit `place_lo` is 1, so every window sits at address 0.
- R2: A host write to control-block offset `CLR_OFS + n` (default 0x010 + n) clears guest n's placement bit. The new value shows on `place_lo` after the clock edge of the write. No other guest's bit changes.
- R3: A host write to control-block offset `SET_OFS + n` (default 0x000 + n) sets guest n's placement bit. No other guest's bit changes.
- R4: A host read at any byte of the control block returns the placement bits on `rd_data`: bit n holds guest n's bit, and all higher bits are 0. The read does not change any placement bit.
- R5: A host access anywhere in guest n's 2 KB data window drives `win_sel_n[n]` low and holds all other selects high. Every offset 0x000 to 0x7FF in the window selects it. Guest n's window starts at `WIN_BASE + n*0x800`.
- R6: When `host_req` is low, all window selects are high and the placement bits keep their value, whatever the address and write inputs are.
- R7: The following host writes leave every placement bit unchanged: a write to a control-block byte that is neither a set byte nor a clear byte, a write inside a data window, and a write to any address outside both regions.
- R8: A host access outside the data windows and the control block asserts no select and returns 0 on `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_req | input | 1 | Host access valid this cycle |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Host byte address |
| rd_data | output | DATA_W | Control-block read data; placement bits in the low bits |
| win_sel_n | output | N_GUEST | Per-guest shared-window select, active low |
| place_lo | output | N_GUEST | Per-guest placement: 1 = window at 0, 0 = window at 512 KB |

## Verification
The bench builds the block with a 20-bit address, four guests, windows at 0xC0000 and the control block at 0xC2000, with set bytes at offset 0x000 and clear bytes at offset 0x010. These values let the bench hit every guest's window at its first byte, its last byte and a middle byte. They also let it step every set and clear byte, and place ignored writes right next to the control offsets (0x004, 0x014) and in neighbouring address space. Clear-then-set sequences on different guests show that each bit changes alone, and reads after each step show the state the guests would see.

// File: rtl/hsw_pkg.sv
// Shared types for the host shared-window map manager.
// Assumes one control access is decoded per clock cycle.
package hsw_pkg;

    // Kind of control-block access found by the fine decode stage
    typedef enum logic [1:0] {
        CK_NONE = 2'd0,
        CK_SET  = 2'd1,
        CK_CLR  = 2'd2,
        CK_READ = 2'd3
    } ctl_kind_e;

endpackage

// File: rtl/hsw_coarse_dec.sv
// Coarse decode stage: compares the upper address bits against the
// window region and the control block. It raises one hit per guest
// window and a carry for the control block.
// Assumes WIN_BASE is aligned to N_GUEST windows and CTRL_BASE to the
// control block size.
module hsw_coarse_dec #(
    parameter int ADDR_W  = 20,
    parameter int N_GUEST = 4,
    parameter int WIN_AW  = 11,
    parameter int CTRL_AW = 9,
    parameter logic [ADDR_W-1:0] WIN_BASE  = 20'hC0000,
    parameter logic [ADDR_W-1:0] CTRL_BASE = 20'hC2000
) (
    input  logic              req,
    input  logic [ADDR_W-1:0] addr,
    output logic [N_GUEST-1:0] win_hit,
    output logic              ctrl_carry
);
    localparam int GIDX_W  = $clog2(N_GUEST);
    localparam int REG_LSB = WIN_AW + GIDX_W;

    logic region_hit;

    // Match the tag bits that cover the whole group of guest windows
    always_comb begin
        region_hit = req && (addr[ADDR_W-1:REG_LSB] == WIN_BASE[ADDR_W-1:REG_LSB]);
    end

    // Match the control block; this is the carry to the fine stage
    always_comb begin
        ctrl_carry = req && (addr[ADDR_W-1:CTRL_AW] == CTRL_BASE[ADDR_W-1:CTRL_AW]);
    end

    // One hit per guest, chosen by the guest index bits above the window offset
    for (genvar g = 0; g < N_GUEST; g++) begin : g_hit
        always_comb begin
            win_hit[g] = region_hit && (addr[REG_LSB-1:WIN_AW] == GIDX_W'(g));
        end
    end

endmodule

// File: rtl/hsw_fine_dec.sv
// Fine decode stage: uses the coarse carry and the low byte-address
// bits to classify a control access as set, clear, read or none, and
// names the target guest for set and clear.
// Assumes the set and clear byte ranges do not overlap.
module hsw_fine_dec
    import hsw_pkg::*;
#(
    parameter int N_GUEST = 4,
    parameter int CTRL_AW = 9,
    parameter int SET_OFS = 'h000,
    parameter int CLR_OFS = 'h010
) (
    input  logic                       carry,
    input  logic                       wr,
    input  logic [CTRL_AW-1:0]         offs,
    output ctl_kind_e                  kind,
    output logic [$clog2(N_GUEST)-1:0] gidx
);
    localparam int GIDX_W = $clog2(N_GUEST);
    localparam logic [CTRL_AW-1:0] SET_LO = CTRL_AW'(SET_OFS);
    localparam logic [CTRL_AW-1:0] SET_HI = CTRL_AW'(SET_OFS + N_GUEST);
    localparam logic [CTRL_AW-1:0] CLR_LO = CTRL_AW'(CLR_OFS);
    localparam logic [CTRL_AW-1:0] CLR_HI = CTRL_AW'(CLR_OFS + N_GUEST);

    logic [CTRL_AW-1:0] dset;
    logic [CTRL_AW-1:0] dclr;
    logic               in_set;
    logic               in_clr;

    // Distance from each control range base, and range membership
    always_comb begin
        dset   = offs - SET_LO;
        dclr   = offs - CLR_LO;
        in_set = (offs >= SET_LO) && (offs < SET_HI);
        in_clr = (offs >= CLR_LO) && (offs < CLR_HI);
    end

    // Classify the access and pick the guest index
    always_comb begin
        kind = CK_NONE;
        gidx = '0;
        if (carry) begin
            if (!wr) begin
                kind = CK_READ;
            end else if (in_set) begin
                kind = CK_SET;
                gidx = dset[GIDX_W-1:0];
            end else if (in_clr) begin
                kind = CK_CLR;
                gidx = dclr[GIDX_W-1:0];
            end
        end
    end

endmodule

// File: rtl/hsw_map_bank.sv
// Per-guest placement flip-flops. Reset loads 1 (window at address 0).
// A set access for a guest loads 1, a clear access loads 0, and
// everything else holds the value.
// Assumes kind/gidx come from a decoder that names one guest at a time.
module hsw_map_bank
    import hsw_pkg::*;
#(
    parameter int N_GUEST = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  ctl_kind_e                  kind,
    input  logic [$clog2(N_GUEST)-1:0] gidx,
    output logic [N_GUEST-1:0]         place_q
);
    localparam int GIDX_W = $clog2(N_GUEST);

    for (genvar g = 0; g < N_GUEST; g++) begin : g_ff
        logic hit;

        // Does this access target this guest
        always_comb begin
            hit = (gidx == GIDX_W'(g));
        end

        // Placement flop: reset to 1, host set/clear only
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                place_q[g] <= 1'b1;
            end else if (hit && (kind == CK_SET)) begin
                place_q[g] <= 1'b1;
            end else if (hit && (kind == CK_CLR)) begin
                place_q[g] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/hsw_map_mgr.sv
// Host shared-window map manager: the top module. It chains the coarse
// and fine decode stages, keeps the per-guest placement bits, drives
// the active-low window selects, and returns the placement bits when
// the host reads the control block.
// Assumes DATA_W >= N_GUEST and N_GUEST >= 2.
module hsw_map_mgr
    import hsw_pkg::*;
#(
    parameter int ADDR_W  = 20,
    parameter int DATA_W  = 8,
    parameter int N_GUEST = 4,
    parameter int WIN_AW  = 11,
    parameter int CTRL_AW = 9,
    parameter int SET_OFS = 'h000,
    parameter int CLR_OFS = 'h010,
    parameter logic [ADDR_W-1:0] WIN_BASE  = 20'hC0000,
    parameter logic [ADDR_W-1:0] CTRL_BASE = 20'hC2000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_req,
    input  logic               host_wr,
    input  logic [ADDR_W-1:0]  host_addr,
    output logic [DATA_W-1:0]  rd_data,
    output logic [N_GUEST-1:0] win_sel_n,
    output logic [N_GUEST-1:0] place_lo
);
    localparam int GIDX_W = $clog2(N_GUEST);

    logic [N_GUEST-1:0] win_hit;
    logic               ctrl_carry;
    ctl_kind_e          kind;
    logic [GIDX_W-1:0]  gidx;
    logic [N_GUEST-1:0] place_q;

    hsw_coarse_dec #(
        .ADDR_W   (ADDR_W),
        .N_GUEST  (N_GUEST),
        .WIN_AW   (WIN_AW),
        .CTRL_AW  (CTRL_AW),
        .WIN_BASE (WIN_BASE),
        .CTRL_BASE(CTRL_BASE)
    ) u_coarse (
        .req       (host_req),
        .addr      (host_addr),
        .win_hit   (win_hit),
        .ctrl_carry(ctrl_carry)
    );

    hsw_fine_dec #(
        .N_GUEST(N_GUEST),
        .CTRL_AW(CTRL_AW),
        .SET_OFS(SET_OFS),
        .CLR_OFS(CLR_OFS)
    ) u_fine (
        .carry(ctrl_carry),
        .wr   (host_wr),
        .offs (host_addr[CTRL_AW-1:0]),
        .kind (kind),
        .gidx (gidx)
    );

    hsw_map_bank #(
        .N_GUEST(N_GUEST)
    ) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .kind   (kind),
        .gidx   (gidx),
        .place_q(place_q)
    );

    // Output drive: active-low selects, placement bits, read mux
    always_comb begin
        win_sel_n = ~win_hit;
        place_lo  = place_q;
        rd_data   = (kind == CK_READ) ? DATA_W'(place_q) : '0;
    end

endmodule

// File: rtl/hsw_map_mgr_chk.sv
// Assertion checker for hsw_map_mgr, attached with bind. It watches
// only the ports of the top module.
module hsw_map_mgr_chk #(
    parameter int ADDR_W  = 20,
    parameter int DATA_W  = 8,
    parameter int N_GUEST = 4,
    parameter int CTRL_AW = 9,
    parameter int SET_OFS = 'h000,
    parameter int CLR_OFS = 'h010,
    parameter logic [ADDR_W-1:0] CTRL_BASE = 20'hC2000
) (
    input logic               clk,
    input logic               rst_n,
    input logic               host_req,
    input logic               host_wr,
    input logic [ADDR_W-1:0]  host_addr,
    input logic [DATA_W-1:0]  rd_data,
    input logic [N_GUEST-1:0] win_sel_n,
    input logic [N_GUEST-1:0] place_lo
);
    logic in_ctrl;
    always_comb begin
        in_ctrl = host_addr[ADDR_W-1:CTRL_AW] == CTRL_BASE[ADDR_W-1:CTRL_AW];
    end

    // R1
    reset_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (place_lo == '1));

    // R5
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~win_sel_n));

    // R6
    idle_no_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !host_req |-> (win_sel_n == '1));

    // R6
    no_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_req && host_wr) |=> $stable(place_lo));

    // R4
    read_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && !host_wr && in_ctrl) |-> (rd_data == DATA_W'(place_lo)));

    for (genvar g = 0; g < N_GUEST; g++) begin : g_ctl
        localparam logic [ADDR_W-1:0] SET_A = CTRL_BASE + ADDR_W'(SET_OFS + g);
        localparam logic [ADDR_W-1:0] CLR_A = CTRL_BASE + ADDR_W'(CLR_OFS + g);

        // R3
        set_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (host_req && host_wr && host_addr == SET_A) |=> place_lo[g]);

        // R2
        clr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (host_req && host_wr && host_addr == CLR_A) |=> !place_lo[g]);
    end

endmodule

bind hsw_map_mgr hsw_map_mgr_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .N_GUEST  (N_GUEST),
    .CTRL_AW  (CTRL_AW),
    .SET_OFS  (SET_OFS),
    .CLR_OFS  (CLR_OFS),
    .CTRL_BASE(CTRL_BASE)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .host_req (host_req),
    .host_wr  (host_wr),
    .host_addr(host_addr),
    .rd_data  (rd_data),
    .win_sel_n(win_sel_n),
    .place_lo (place_lo)
);

// File: tb/hsw_map_mgr_tb.sv
`timescale 1ns/1ps
// Directed bench for hsw_map_mgr: one task per scenario.
module hsw_map_mgr_tb;
    localparam int ADDR_W  = 20;
    localparam int DATA_W  = 8;
    localparam int N_GUEST = 4;
    localparam logic [19:0] WB = 20'hC0000;
    localparam logic [19:0] CB = 20'hC2000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              host_req = 1'b0;
    logic              host_wr = 1'b0;
    logic [ADDR_W-1:0] host_addr = '0;
    logic [DATA_W-1:0] rd_data;
    logic [N_GUEST-1:0] win_sel_n;
    logic [N_GUEST-1:0] place_lo;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [DATA_W-1:0]  cap_rd;
    logic [N_GUEST-1:0] cap_sel;
    logic [N_GUEST-1:0] model;

    always #2.5 clk = ~clk;

    hsw_map_mgr #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_GUEST(N_GUEST),
        .WIN_AW(11), .CTRL_AW(9), .SET_OFS('h000), .CLR_OFS('h010),
        .WIN_BASE(WB), .CTRL_BASE(CB)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_wr(host_wr),
        .host_addr(host_addr), .rd_data(rd_data), .win_sel_n(win_sel_n),
        .place_lo(place_lo)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One host access: drive at negedge, capture comb outputs, pass a clock edge
    task automatic access(input logic [ADDR_W-1:0] a, input logic wr, input logic req);
        @(negedge clk);
        host_addr = a;
        host_wr   = wr;
        host_req  = req;
        #1;
        cap_rd  = rd_data;
        cap_sel = win_sel_n;
        @(posedge clk);
        #1;
        host_req = 1'b0;
        host_wr  = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(place_lo == 4'hF, "R1", "place during reset", place_lo, 4'hF);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check(place_lo == 4'hF, "R1", "place after reset", place_lo, 4'hF);
        check(win_sel_n == 4'hF, "R6", "idle selects", win_sel_n, 4'hF);
        model = 4'hF;
    endtask

    task automatic t_window();
        int offs[3] = '{'h000, 'h3A5, 'h7FF};
        for (int g = 0; g < N_GUEST; g++) begin
            for (int k = 0; k < 3; k++) begin
                access(WB + 20'(g * 'h800 + offs[k]), k[0], 1'b1);
                check(cap_sel == ~(4'b1 << g), "R5", "window select", cap_sel, ~(4'b1 << g));
                check(place_lo == model, "R7", "window access keeps place", place_lo, model);
            end
        end
    endtask

    task automatic t_clear_set();
        for (int g = 0; g < N_GUEST; g++) begin
            access(CB + 20'('h010 + g), 1'b1, 1'b1);
            model[g] = 1'b0;
            check(place_lo == model, "R2", "clear guest", place_lo, model);
        end
        access(CB + 20'h002, 1'b1, 1'b1);
        model[2] = 1'b1;
        check(place_lo == model, "R3", "set guest 2", place_lo, model);
        access(CB + 20'h000, 1'b1, 1'b1);
        model[0] = 1'b1;
        check(place_lo == model, "R3", "set guest 0", place_lo, model);
    endtask

    task automatic t_read();
        access(CB + 20'h040, 1'b0, 1'b1);
        check(cap_rd == DATA_W'(model), "R4", "read mid block", cap_rd, model);
        check(place_lo == model, "R4", "read keeps place", place_lo, model);
        access(CB + 20'h1FF, 1'b0, 1'b1);
        check(cap_rd == DATA_W'(model), "R4", "read last byte", cap_rd, model);
        access(CB + 20'h013, 1'b0, 1'b1);
        check(place_lo == model, "R4", "read at clear byte", place_lo, model);
    endtask

    task automatic t_ignored();
        access(CB + 20'h004, 1'b1, 1'b1);
        check(place_lo == model, "R7", "write 0x004", place_lo, model);
        access(CB + 20'h014, 1'b1, 1'b1);
        check(place_lo == model, "R7", "write 0x014", place_lo, model);
        access(20'h00011, 1'b1, 1'b1);
        check(place_lo == model, "R7", "write outside", place_lo, model);
        access(CB + 20'h011, 1'b1, 1'b0);
        check(cap_sel == 4'hF, "R6", "no req select", cap_sel, 4'hF);
        check(place_lo == model, "R6", "no req write", place_lo, model);
        access(WB + 20'h800, 1'b0, 1'b0);
        check(cap_sel == 4'hF, "R6", "no req window", cap_sel, 4'hF);
    endtask

    task automatic t_outside();
        access(CB + 20'h200, 1'b0, 1'b1);
        check(cap_sel == 4'hF, "R8", "outside select", cap_sel, 4'hF);
        check(cap_rd == '0, "R8", "outside read", cap_rd, 0);
        access(WB - 20'h1, 1'b0, 1'b1);
        check(cap_sel == 4'hF, "R8", "below window select", cap_sel, 4'hF);
        check(cap_rd == '0, "R8", "window read data", cap_rd, 0);
    endtask

    initial begin
        t_reset();
        t_window();
        t_clear_set();
        t_read();
        t_ignored();
        t_outside();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule